// File: doc/BRIEF.md
# Fetch Address Selector with Static Next-Address Guess

This block sits in the fetch stage of a five-stage in-order pipeline. Every cycle it does two jobs. It picks the address that instruction fetch should use, and it forms a guess of the address that follows the instruction being fetched. The guess is written into a held register, which feeds the next cycle's selection.

The guess is static. Ordinary instructions are followed by their sequential address. Calls and all jumps, conditional or not, are followed by their encoded target. For a return no guess is attempted: the sequential address is stored, and the surrounding control is expected to stall fetch until the return resolves.

Two later stages can override the stored guess:
- A conditional jump that resolves not taken in the memory stage supplies its fall-through address on the memory-stage operand field.
- A return in the write-back stage supplies the address it loaded from the stack.

The memory-stage correction has the higher priority, because it belongs to the younger instruction.

Top module: `npc_select`

## Requirements
- R1: While reset is held, the stored guess `predPc` equals parameter `RESET_PC`. With no correction active, `fetchPc` also equals `RESET_PC`.
- R2: When `fCode` is not a jump (7), a call (8) or a return (9), `nextPred` equals `fValP`. Examples are halt (0), immediate load (3) and ALU (6).
- R3: When `fCode` is a jump (7) or a call (8), `nextPred` equals `fValC`. Every jump is guessed taken.
- R4: When `fCode` is a return (9), `nextPred` equals `fValP`. `fValC` is ignored.
- R5: When `mCode` is a jump (7) and `mCond` is 0, `fetchPc` equals `mValA` in the same cycle.
- R6: When `wCode` is a return (9) and R5 does not apply, `fetchPc` equals `wValM` in the same cycle.
- R7: When the R5 and R6 conditions hold together, `fetchPc` equals `mValA`.
- R8: When neither the R5 nor the R6 condition holds, `fetchPc` equals `predPc`. This includes a memory-stage jump with `mCond`=1, a non-jump with `mCond`=0, and a call (8) in write-back.
- R9: On a rising clock edge with `fetchStall` low, `predPc` takes the value `nextPred` had before the edge.
- R10: On a rising clock edge with `fetchStall` high, `predPc` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchStall | input | 1 | Hold the stored guess |
| fCode | input | 4 | Code of the instruction in fetch |
| fValC | input | ADDR_W | Constant field of the fetched instruction |
| fValP | input | ADDR_W | Sequential address after the fetched instruction |
| mCode | input | 4 | Code of the instruction in the memory stage |
| mCond | input | 1 | Jump condition resolved for the memory-stage instruction |
| mValA | input | ADDR_W | Memory-stage operand field (fall-through for jumps) |
| wCode | input | 4 | Code of the instruction in write-back |
| wValM | input | ADDR_W | Value loaded by the write-back instruction |
| fetchPc | output | ADDR_W | Address to fetch this cycle |
| nextPred | output | ADDR_W | Guess for the following fetch address |
| predPc | output | ADDR_W | Stored guess register |

## Verification
The only internal state is the stored guess, so a wrong load or a wrong hold shows up on `predPc` one edge after the fault. It also shows up on `fetchPc` in that same cycle whenever no correction is active. A swapped priority, or a wrong decode of either correction source, is purely combinational and is visible on `fetchPc` in the cycle the stimulus is applied. A wrong guess decode is visible on `nextPred` in the cycle the stimulus is applied. For this reason the table checks are made with the register frozen at a known value, and the register is then exercised separately across load and hold edges.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    OP_HALT   = 4'h0,
    OP_NOP    = 4'h1,
    OP_MOVE   = 4'h2,
    OP_LDIMM  = 4'h3,
    OP_STORE  = 4'h4,
    OP_LOAD   = 4'h5,
    OP_ALU    = 4'h6,
    OP_JUMP   = 4'h7,
    OP_CALL   = 4'h8,
    OP_RET    = 4'h9,
    OP_PUSH   = 4'hA,
    OP_POP    = 4'hB
  } opcode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeRecover;   // memory-stage not-taken jump redirect
    logic takeReturn;    // write-back return redirect
    logic guessTarget;   // next guess comes from the constant field
  } selStrobes_t;

endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic [3:0]  fCode,
  input  logic [3:0]  mCode,
  input  logic        mCond,
  input  logic [3:0]  wCode,
  output selStrobes_t strobes
);

  logic recoverHit;
  logic returnHit;

  always_comb begin
    recoverHit = (mCode == OP_JUMP) && !mCond;
    returnHit  = (wCode == OP_RET);

    // Memory stage wins: it holds the younger instruction.
    strobes.takeRecover = recoverHit;
    strobes.takeReturn  = returnHit && !recoverHit;

    unique case (fCode)
      OP_JUMP, OP_CALL: strobes.guessTarget = 1'b1;
      default:          strobes.guessTarget = 1'b0;  // includes return: no guess
    endcase
  end

  a_r7_onehot_redirect: assert final ($onehot0({strobes.takeRecover, strobes.takeReturn}));

endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchStall,
  input  selStrobes_t       strobes,
  input  logic [ADDR_W-1:0] fValC,
  input  logic [ADDR_W-1:0] fValP,
  input  logic [ADDR_W-1:0] mValA,
  input  logic [ADDR_W-1:0] wValM,
  output logic [ADDR_W-1:0] fetchPc,
  output logic [ADDR_W-1:0] nextPred,
  output logic [ADDR_W-1:0] predPc
);

  always_comb begin
    if (strobes.takeRecover)     fetchPc = mValA;
    else if (strobes.takeReturn) fetchPc = wValM;
    else                         fetchPc = predPc;
  end

  assign nextPred = strobes.guessTarget ? fValC : fValP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            predPc <= RESET_PC;
    else if (!fetchStall) predPc <= nextPred;
  end

  a_r9_load_guess: assert property (@(posedge clk) disable iff (!rstN)
    !fetchStall |=> predPc == $past(nextPred));

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    fetchStall |=> $stable(predPc));

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchStall,
  input  logic [3:0]        fCode,
  input  logic [ADDR_W-1:0] fValC,
  input  logic [ADDR_W-1:0] fValP,
  input  logic [3:0]        mCode,
  input  logic              mCond,
  input  logic [ADDR_W-1:0] mValA,
  input  logic [3:0]        wCode,
  input  logic [ADDR_W-1:0] wValM,
  output logic [ADDR_W-1:0] fetchPc,
  output logic [ADDR_W-1:0] nextPred,
  output logic [ADDR_W-1:0] predPc
);

  selStrobes_t strobes;

  npc_ctrl u_ctrl (
    .fCode   (fCode),
    .mCode   (mCode),
    .mCond   (mCond),
    .wCode   (wCode),
    .strobes (strobes)
  );

  npc_datapath #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .fetchStall (fetchStall),
    .strobes    (strobes),
    .fValC      (fValC),
    .fValP      (fValP),
    .mValA      (mValA),
    .wValM      (wValM),
    .fetchPc    (fetchPc),
    .nextPred   (nextPred),
    .predPc     (predPc)
  );

  // Port-level checks against the requirements
  a_r5_recover_jump: assert property (@(posedge clk) disable iff (!rstN)
    (mCode == OP_JUMP && !mCond) |-> fetchPc == mValA);

  a_r6_return_addr: assert property (@(posedge clk) disable iff (!rstN)
    (wCode == OP_RET && !(mCode == OP_JUMP && !mCond)) |-> fetchPc == wValM);

  a_r8_use_guess: assert property (@(posedge clk) disable iff (!rstN)
    (wCode != OP_RET && !(mCode == OP_JUMP && !mCond)) |-> fetchPc == predPc);

  a_r3_target_guess: assert property (@(posedge clk) disable iff (!rstN)
    (fCode == OP_JUMP || fCode == OP_CALL) |-> nextPred == fValC);

  a_r1_reset_value: assert property (@(posedge clk)
    !rstN |-> predPc == RESET_PC);

endmodule

// File: tb/npc_select_bench.sv
module npc_select_bench;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          fetchStall = 1'b1;
  logic [3:0]    fCode = 4'h1;
  logic [AW-1:0] fValC = '0;
  logic [AW-1:0] fValP = '0;
  logic [3:0]    mCode = 4'h1;
  logic          mCond = 1'b0;
  logic [AW-1:0] mValA = '0;
  logic [3:0]    wCode = 4'h1;
  logic [AW-1:0] wValM = '0;
  logic [AW-1:0] fetchPc, nextPred, predPc;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  npc_select #(.ADDR_W(AW), .RESET_PC(32'h0)) u_npc_select (
    .clk(clk), .rstN(rstN), .fetchStall(fetchStall),
    .fCode(fCode), .fValC(fValC), .fValP(fValP),
    .mCode(mCode), .mCond(mCond), .mValA(mValA),
    .wCode(wCode), .wValM(wValM),
    .fetchPc(fetchPc), .nextPred(nextPred), .predPc(predPc)
  );

  typedef struct packed {
    logic [7:0]    req;
    logic [3:0]    fc;
    logic [AW-1:0] vc;
    logic [AW-1:0] vp;
    logic [3:0]    mc;
    logic          mk;
    logic [AW-1:0] ma;
    logic [3:0]    wc;
    logic [AW-1:0] wm;
    logic [AW-1:0] expFetch;
    logic [AW-1:0] expNext;
  } vec_t;

  localparam int NV = 12;
  // The stored guess is frozen at 0 while the table runs.
  localparam vec_t VECS [NV] = '{
    '{8'd2, 4'h6, 32'h100, 32'h12, 4'h1, 1'b0, 32'h0,  4'h1, 32'h0,  32'h0,  32'h12},  // R2 alu
    '{8'd2, 4'h3, 32'h104, 32'h26, 4'h1, 1'b0, 32'h0,  4'h1, 32'h0,  32'h0,  32'h26},  // R2 ldimm
    '{8'd3, 4'h7, 32'h200, 32'h30, 4'h1, 1'b0, 32'h0,  4'h1, 32'h0,  32'h0,  32'h200}, // R3 jump
    '{8'd3, 4'h8, 32'h340, 32'h35, 4'h1, 1'b0, 32'h0,  4'h1, 32'h0,  32'h0,  32'h340}, // R3 call
    '{8'd4, 4'h9, 32'h999, 32'h51, 4'h1, 1'b0, 32'h0,  4'h1, 32'h0,  32'h0,  32'h51},  // R4 ret
    '{8'd5, 4'h1, 32'h0,   32'h61, 4'h7, 1'b0, 32'h77, 4'h1, 32'h0,  32'h77, 32'h61},  // R5
    '{8'd8, 4'h1, 32'h0,   32'h62, 4'h7, 1'b1, 32'h78, 4'h1, 32'h0,  32'h0,  32'h62},  // R8 taken
    '{8'd6, 4'h1, 32'h0,   32'h63, 4'h1, 1'b0, 32'h0,  4'h9, 32'h88, 32'h88, 32'h63},  // R6
    '{8'd7, 4'h1, 32'h0,   32'h64, 4'h7, 1'b0, 32'h77, 4'h9, 32'h88, 32'h77, 32'h64},  // R7
    '{8'd8, 4'h1, 32'h0,   32'h65, 4'h6, 1'b0, 32'h55, 4'h1, 32'h0,  32'h0,  32'h65},  // R8 alu
    '{8'd8, 4'h1, 32'h0,   32'h66, 4'h1, 1'b0, 32'h0,  4'h8, 32'h66, 32'h0,  32'h66},  // R8 call
    '{8'd2, 4'h0, 32'h70,  32'h13, 4'h1, 1'b0, 32'h0,  4'h1, 32'h0,  32'h0,  32'h13}   // R2 halt
  };

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 predPc in reset", predPc, 32'h0);
    check("R1 fetchPc in reset", fetchPc, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      fCode = VECS[i].fc; fValC = VECS[i].vc; fValP = VECS[i].vp;
      mCode = VECS[i].mc; mCond = VECS[i].mk; mValA = VECS[i].ma;
      wCode = VECS[i].wc; wValM = VECS[i].wm;
      #1;
      check($sformatf("R%0d fetchPc vec %0d", VECS[i].req, i), fetchPc, VECS[i].expFetch);
      check($sformatf("R%0d nextPred vec %0d", VECS[i].req, i), nextPred, VECS[i].expNext);
      @(negedge clk);
    end

    // R9: load on an unstalled edge
    mCode = 4'h1; wCode = 4'h1;
    fCode = 4'h7; fValC = 32'h400; fValP = 32'h10;
    fetchStall = 1'b0;
    @(negedge clk);
    check("R9 predPc loaded", predPc, 32'h400);
    check("R9 fetchPc follows guess", fetchPc, 32'h400);

    // R10: hold on a stalled edge
    fetchStall = 1'b1;
    fValC = 32'h500;
    @(negedge clk);
    check("R10 predPc held", predPc, 32'h400);
    check("R10 fetchPc held", fetchPc, 32'h400);

    // R9: release and load the sequential guess
    fetchStall = 1'b0;
    fCode = 4'h6; fValP = 32'h52C;
    @(negedge clk);
    check("R9 predPc loads valP", predPc, 32'h52C);

    // R1: asynchronous reset returns the guess to the reset address
    rstN = 1'b0;
    #1;
    check("R1 predPc after reset", predPc, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule